// File: doc/BRIEF.md
# Count-Driven Byte Transfer Sequencer

This block runs the controller side of a byte-oriented serial bus transfer. Software programs a target address, a byte count and a control word that holds enable, controller-role, direction, repeat-mode, start and stop bits. The sequencer then drives an abstract bus port one operation at a time: start-with-address, send one byte and collect its acknowledge, receive one byte, or stop. Outgoing bytes come from a small transmit holding buffer that the host fills. Incoming bytes land in a receive holding buffer that the host drains.

In count mode a live counter is loaded from the programmed count when the start succeeds and drops by one for each byte moved. When it reaches zero the sequencer either issues a stop (if stop was requested) or raises an access-ready event, gives up the controller role and keeps the bus claimed. In repeat mode the count is ignored. The sequencer keeps moving bytes for as long as the buffers allow, and only a stop request ends the transfer. A refused address or a refused data byte raises a no-acknowledge event and withdraws the stop request. When the `CLR_ON_DISABLE` variant is selected, clearing the enable bit puts the whole controller back to its reset state.

Top module: `cnt_xfer_seq`

## Requirements
- R1: A control write keeps only bits 15, 14, 11, 10, 9, 8, 7, 2, 1 and 0 of the written word (mask 0xCF87), and `ctl_q` reads it back. Bit 15 is enable, 10 controller role, 9 transmit direction, 8 wide addressing, 2 repeat mode, 1 stop request and 0 start request.
- R2: A control write in idle with enable, controller role and start set (and bit 8 clear) issues a START operation carrying `tgt_addr`, with `bus_rd` equal to the inverse of bit 9. The start bit clears itself when that operation completes.
- R3: If the address is not acknowledged, `nack_flag` is set, the stop bit is cleared, the bus is not claimed and no data operation follows.
- R4: On an acknowledged start the live count `cnt_live` is loaded from the programmed count. In count mode each acknowledged byte sent takes the next byte from the transmit buffer in push order and lowers the count by one, and no data operation is issued while the count is zero. `tx_rdy` is high while transferring with count remaining and buffer space free.
- R5: In count-mode receive, bytes are read until the count is zero or the receive buffer holds `BUF_DEPTH` bytes, and they reach `rx_head` in arrival order. `rx_rdy` is high whenever the buffer holds a byte.
- R6: When the count is exhausted with stop requested, a STOP operation is issued. Once it completes, the stop bit is cleared, `cnt_live` is reloaded from the programmed count, the transmit buffer is emptied and `link_busy` falls.
- R7: When the count is exhausted without stop, `acc_rdy` is set, the controller-role bit is cleared, no STOP is issued and `link_busy` stays high. A later control write with the controller role and stop set (start clear) issues the STOP.
- R8: In repeat mode the count neither limits nor changes. Transmit sends every buffered byte and keeps `tx_rdy` high. Receive fills the buffer to `BUF_DEPTH` bytes, with `rx_rdy` high when full. A stop request written during the transfer ends it with a STOP after any outstanding operation.
- R9: A data byte that is not acknowledged sets `nack_flag`, clears the stop bit, stays in the buffer, and leaves the sequencer idle without issuing STOP.
- R10: With `CLR_ON_DISABLE` = 1, a control write in idle with bit 15 clear empties both buffers and clears the programmed and live counts, `acc_rdy`, `nack_flag` and `link_busy`, while `ctl_q` takes the masked written value.
- R11: A push into a full transmit buffer is ignored: the level stays at `BUF_DEPTH` and that byte is never sent.
- R12: `evt_clr` bit 0 clears `acc_rdy` and bit 1 clears `nack_flag`. A new event in the same cycle wins.
- R13: Bus operation codes are START=0, WRITE=1, READ=2, STOP=3. Once `bus_vld` is high it stays high with the same code until a cycle with `bus_rdy` high completes the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| cnt_wr | input | 1 | Programmed count write strobe |
| cnt_wdata | input | CNT_W | Programmed byte count |
| tgt_addr | input | ADDR_W | Target address sent with START |
| evt_clr | input | 2 | Event clear: bit 0 access-ready, bit 1 no-acknowledge |
| host_tx_vld | input | 1 | Push a byte into the transmit buffer |
| host_tx_byte | input | 8 | Byte to push |
| host_rx_pop | input | 1 | Remove the head byte of the receive buffer |
| rx_head | output | 8 | Oldest received byte |
| tx_level | output | LVL_W | Bytes in the transmit buffer |
| rx_level | output | LVL_W | Bytes in the receive buffer |
| ctl_q | output | 16 | Control word readback |
| cnt_live | output | CNT_W | Live byte counter |
| tx_rdy | output | 1 | Transmit-ready event |
| rx_rdy | output | 1 | Receive-ready event |
| acc_rdy | output | 1 | Access-ready event (sticky) |
| nack_flag | output | 1 | No-acknowledge event (sticky) |
| seq_busy | output | 1 | Sequencer not idle |
| link_busy | output | 1 | Bus claimed by this controller |
| bus_vld | output | 1 | Bus operation request |
| bus_op | output | 2 | Operation code |
| bus_addr | output | ADDR_W | Address for START |
| bus_rd | output | 1 | Read direction for START |
| bus_wbyte | output | 8 | Byte for WRITE |
| bus_rdy | input | 1 | Operation completes this cycle |
| bus_ack | input | 1 | Acknowledge for START and WRITE |
| bus_rbyte | input | 8 | Byte returned by READ |

## Verification
The hardest state to reach from the ports is a receive transfer parked mid-count with a full buffer, which then resumes as the host drains it. The stimulus starts a count larger than the buffer, leaves the buffer unread until reads stop, and then pops bytes while new reads arrive, so a push and a pop land in the same cycle. Acknowledge refusals are placed on a chosen byte index by the bus model, and a random operation-completion delay keeps the operation-hold rule under steady load. Directed cases are mixed with seeded random transmit and receive runs of varying length and address.

// File: rtl/cxs_pkg.sv
package cxs_pkg;
   localparam logic [15:0] CTL_MASK = 16'hCF87;
   localparam int CB_EN  = 15;
   localparam int CB_MST = 10;
   localparam int CB_TRX = 9;
   localparam int CB_XA  = 8;
   localparam int CB_RM  = 2;
   localparam int CB_STP = 1;
   localparam int CB_STT = 0;

   typedef enum logic [1:0] {
      BOP_START = 2'd0,
      BOP_WRITE = 2'd1,
      BOP_READ  = 2'd2,
      BOP_STOP  = 2'd3
   } bus_op_e;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_START = 2'd1,
      SQ_XFER  = 2'd2,
      SQ_STOP  = 2'd3
   } seq_state_e;
endpackage

// File: rtl/cxs_byte_fifo.sv
module cxs_byte_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 4,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [LVL_W-1:0] level
);
   localparam int PW = $clog2(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         initial $fatal(1, "cxs_byte_fifo: DEPTH must be at least 2");
      end
      if (LVL_W < $clog2(DEPTH + 1)) begin : g_bad_lvl
         initial $fatal(1, "cxs_byte_fifo: LVL_W too narrow for DEPTH");
      end
   endgenerate

   logic [DW-1:0]    mem [DEPTH];
   logic [PW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [LVL_W-1:0] cnt;
   logic             do_push, do_pop;

   assign do_push = push && (cnt != LVL_W'(DEPTH));
   assign do_pop  = pop && (cnt != '0);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap
         assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (flush) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         cnt <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wp] <= din;
   end

   assign dout  = mem[rp];
   assign level = cnt;
endmodule

// File: rtl/cxs_seq_fsm.sv
module cxs_seq_fsm
   import cxs_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter int DEPTH          = 4,
   parameter int LVL_W          = $clog2(DEPTH + 1),
   parameter bit CLR_ON_DISABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [15:0]      ctl_wdata,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic [1:0]       evt_clr,
   input  logic [LVL_W-1:0] tx_level,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             bus_rdy,
   input  logic             bus_ack,
   output logic [15:0]      ctl_q,
   output logic [CNT_W-1:0] cnt_live,
   output logic             acc_rdy,
   output logic             nack_flag,
   output logic             tx_rdy,
   output logic             rx_rdy,
   output logic             seq_busy,
   output logic             link_busy,
   output logic             bus_vld,
   output logic [1:0]       bus_op,
   output logic             bus_rd,
   output logic             tx_pop,
   output logic             rx_push,
   output logic             tx_flush,
   output logic             rx_flush
);
   seq_state_e       state_q;
   logic [15:0]      ctl;
   logic [CNT_W-1:0] cnt_prog, cnt_cur;
   logic             link_q, acc_q, nack_q, hold_q;

   logic rm, trx, stp, tx_full, rx_full, tx_any, cnt_ok, rm_end;
   logic want_wr, want_rd, xfer_vld, hs, soft_rst;
   bus_op_e op_c;

   assign rm      = ctl[CB_RM];
   assign trx     = ctl[CB_TRX];
   assign stp     = ctl[CB_STP];
   assign tx_full = (tx_level == LVL_W'(DEPTH));
   assign rx_full = (rx_level == LVL_W'(DEPTH));
   assign tx_any  = (tx_level != '0);
   assign cnt_ok  = rm || (cnt_cur != '0);
   assign rm_end  = rm && stp && !hold_q;
   assign want_wr = trx && tx_any && cnt_ok && !rm_end;
   assign want_rd = !trx && !rx_full && cnt_ok && !rm_end;
   assign xfer_vld = hold_q || want_wr || want_rd;

   always_comb begin
      bus_vld = 1'b0;
      op_c    = BOP_START;
      unique case (state_q)
         SQ_START: begin bus_vld = 1'b1;     op_c = BOP_START; end
         SQ_XFER:  begin bus_vld = xfer_vld; op_c = trx ? BOP_WRITE : BOP_READ; end
         SQ_STOP:  begin bus_vld = 1'b1;     op_c = BOP_STOP; end
         default:  begin bus_vld = 1'b0;     op_c = BOP_START; end
      endcase
   end

   assign bus_op  = op_c;
   assign bus_rd  = !trx;
   assign hs      = bus_vld && bus_rdy;
   assign tx_pop  = (state_q == SQ_XFER) && hs && trx && bus_ack;
   assign rx_push = (state_q == SQ_XFER) && hs && !trx;

   generate
      if (CLR_ON_DISABLE) begin : g_clr_dis
         assign soft_rst = ctl_wr && !ctl_wdata[CB_EN] && (state_q == SQ_IDLE);
      end else begin : g_keep_dis
         assign soft_rst = 1'b0;
      end
   endgenerate

   assign rx_flush = soft_rst || ((state_q == SQ_START) && hs);
   assign tx_flush = soft_rst || ((state_q == SQ_STOP) && hs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         ctl      <= '0;
         cnt_prog <= '0;
         cnt_cur  <= '0;
         link_q   <= 1'b0;
         acc_q    <= 1'b0;
         nack_q   <= 1'b0;
         hold_q   <= 1'b0;
      end else begin
         if (evt_clr[0]) acc_q  <= 1'b0;
         if (evt_clr[1]) nack_q <= 1'b0;
         if (cnt_wr) cnt_prog <= cnt_wdata;
         hold_q <= (state_q == SQ_XFER) && bus_vld && !bus_rdy;
         if (ctl_wr && (state_q != SQ_IDLE) && ctl_wdata[CB_STP])
            ctl[CB_STP] <= 1'b1;

         unique case (state_q)
            SQ_IDLE: begin
               if (ctl_wr) begin
                  ctl <= ctl_wdata & CTL_MASK;
                  if (soft_rst) begin
                     cnt_prog <= '0;
                     cnt_cur  <= '0;
                     acc_q    <= 1'b0;
                     nack_q   <= 1'b0;
                     link_q   <= 1'b0;
                  end else if (ctl_wdata[CB_EN] && ctl_wdata[CB_MST] &&
                               !ctl_wdata[CB_XA]) begin
                     if (ctl_wdata[CB_STT])
                        state_q <= SQ_START;
                     else if (link_q)
                        state_q <= SQ_XFER;
                  end
               end
            end
            SQ_START: begin
               if (hs) begin
                  ctl[CB_STT] <= 1'b0;
                  if (bus_ack) begin
                     link_q  <= 1'b1;
                     cnt_cur <= cnt_prog;
                     state_q <= SQ_XFER;
                  end else begin
                     nack_q      <= 1'b1;
                     ctl[CB_STP] <= 1'b0;
                     link_q      <= 1'b0;
                     state_q     <= SQ_IDLE;
                  end
               end
            end
            SQ_XFER: begin
               if (hs) begin
                  if (trx && !bus_ack) begin
                     nack_q      <= 1'b1;
                     ctl[CB_STP] <= 1'b0;
                     state_q     <= SQ_IDLE;
                  end else if (!rm) begin
                     cnt_cur <= cnt_cur - 1'b1;
                  end
               end else if (!bus_vld) begin
                  if (rm_end) begin
                     state_q <= SQ_STOP;
                  end else if (!rm && (cnt_cur == '0)) begin
                     if (stp) begin
                        state_q <= SQ_STOP;
                     end else begin
                        acc_q       <= 1'b1;
                        ctl[CB_MST] <= 1'b0;
                        state_q     <= SQ_IDLE;
                     end
                  end
               end
            end
            SQ_STOP: begin
               if (hs) begin
                  ctl[CB_STP] <= 1'b0;
                  cnt_cur     <= cnt_prog;
                  link_q      <= 1'b0;
                  state_q     <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign ctl_q     = ctl;
   assign cnt_live  = cnt_cur;
   assign acc_rdy   = acc_q;
   assign nack_flag = nack_q;
   assign seq_busy  = (state_q != SQ_IDLE);
   assign link_busy = link_q;
   assign tx_rdy    = (state_q == SQ_XFER) && trx && cnt_ok && !tx_full;
   assign rx_rdy    = rm ? rx_full : (rx_level != '0);
endmodule

// File: rtl/cnt_xfer_seq.sv
module cnt_xfer_seq #(
   parameter int CNT_W          = 16,
   parameter int ADDR_W         = 10,
   parameter int BUF_DEPTH      = 4,
   parameter int LVL_W          = $clog2(BUF_DEPTH + 1),
   parameter bit CLR_ON_DISABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [15:0]       ctl_wdata,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  cnt_wdata,
   input  logic [ADDR_W-1:0] tgt_addr,
   input  logic [1:0]        evt_clr,
   input  logic              host_tx_vld,
   input  logic [7:0]        host_tx_byte,
   input  logic              host_rx_pop,
   output logic [7:0]        rx_head,
   output logic [LVL_W-1:0]  tx_level,
   output logic [LVL_W-1:0]  rx_level,
   output logic [15:0]       ctl_q,
   output logic [CNT_W-1:0]  cnt_live,
   output logic              tx_rdy,
   output logic              rx_rdy,
   output logic              acc_rdy,
   output logic              nack_flag,
   output logic              seq_busy,
   output logic              link_busy,
   output logic              bus_vld,
   output logic [1:0]        bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic [7:0]        bus_wbyte,
   input  logic              bus_rdy,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rbyte
);
   generate
      if (CNT_W < 1 || ADDR_W < 7) begin : g_bad_width
         initial $fatal(1, "cnt_xfer_seq: CNT_W >= 1 and ADDR_W >= 7 required");
      end
   endgenerate

   logic tx_pop, rx_push, tx_flush, rx_flush;

   cxs_byte_fifo #(.DW(8), .DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_txbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush),
      .push  (host_tx_vld),
      .din   (host_tx_byte),
      .pop   (tx_pop),
      .dout  (bus_wbyte),
      .level (tx_level)
   );

   cxs_byte_fifo #(.DW(8), .DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_rxbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush),
      .push  (rx_push),
      .din   (bus_rbyte),
      .pop   (host_rx_pop),
      .dout  (rx_head),
      .level (rx_level)
   );

   cxs_seq_fsm #(
      .CNT_W(CNT_W), .DEPTH(BUF_DEPTH), .LVL_W(LVL_W), .CLR_ON_DISABLE(CLR_ON_DISABLE)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .ctl_wdata (ctl_wdata),
      .cnt_wr    (cnt_wr),
      .cnt_wdata (cnt_wdata),
      .evt_clr   (evt_clr),
      .tx_level  (tx_level),
      .rx_level  (rx_level),
      .bus_rdy   (bus_rdy),
      .bus_ack   (bus_ack),
      .ctl_q     (ctl_q),
      .cnt_live  (cnt_live),
      .acc_rdy   (acc_rdy),
      .nack_flag (nack_flag),
      .tx_rdy    (tx_rdy),
      .rx_rdy    (rx_rdy),
      .seq_busy  (seq_busy),
      .link_busy (link_busy),
      .bus_vld   (bus_vld),
      .bus_op    (bus_op),
      .bus_rd    (bus_rd),
      .tx_pop    (tx_pop),
      .rx_push   (rx_push),
      .tx_flush  (tx_flush),
      .rx_flush  (rx_flush)
   );

   assign bus_addr = tgt_addr;
endmodule

// File: rtl/cnt_xfer_seq_chk.sv
module cnt_xfer_seq_chk #(
   parameter int CNT_W = 16,
   parameter int DEPTH = 4,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_vld,
   input logic             bus_rdy,
   input logic             bus_ack,
   input logic [1:0]       bus_op,
   input logic [15:0]      ctl_q,
   input logic [CNT_W-1:0] cnt_live,
   input logic             acc_rdy,
   input logic             nack_flag,
   input logic [LVL_W-1:0] tx_level,
   input logic             link_busy
);
   logic hs;
   assign hs = bus_vld && bus_rdy;

   // R13
   op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_vld && !bus_rdy |=> bus_vld && $stable(bus_op));

   // R2
   start_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs && bus_op == 2'd0 |=> !ctl_q[0]);

   // R3
   addr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs && bus_op == 2'd0 && !bus_ack |=> nack_flag && !ctl_q[1] && !link_busy);

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs && bus_op == 2'd1 && bus_ack && !ctl_q[2] |=> cnt_live == $past(cnt_live) - CNT_W'(1));

   // R4
   no_data_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_vld && (bus_op == 2'd1 || bus_op == 2'd2) && !ctl_q[2] |-> cnt_live != '0);

   // R6
   stop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs && bus_op == 2'd3 |=> !ctl_q[1] && tx_level == '0 && !link_busy);

   // R7
   access_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(acc_rdy) |-> !ctl_q[10] && link_busy);

   // R9
   data_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs && bus_op == 2'd1 && !bus_ack |=> nack_flag && !ctl_q[1]);

   // R11
   tx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LVL_W'(DEPTH));
endmodule

bind cnt_xfer_seq cnt_xfer_seq_chk #(.CNT_W(CNT_W), .DEPTH(BUF_DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_vld   (bus_vld),
   .bus_rdy   (bus_rdy),
   .bus_ack   (bus_ack),
   .bus_op    (bus_op),
   .ctl_q     (ctl_q),
   .cnt_live  (cnt_live),
   .acc_rdy   (acc_rdy),
   .nack_flag (nack_flag),
   .tx_level  (tx_level),
   .link_busy (link_busy)
);

// File: tb/tb_cnt_xfer_seq.sv
`timescale 1ns/1ps
module tb_cnt_xfer_seq;
   localparam int CNT_W = 16;
   localparam int ADDR_W = 10;
   localparam int DEPTH = 4;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic cnt_wr = 1'b0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic [ADDR_W-1:0] tgt_addr = '0;
   logic [1:0] evt_clr = '0;
   logic host_tx_vld = 1'b0;
   logic [7:0] host_tx_byte = '0;
   logic host_rx_pop = 1'b0;
   logic [7:0] rx_head;
   logic [LVL_W-1:0] tx_level, rx_level;
   logic [15:0] ctl_q;
   logic [CNT_W-1:0] cnt_live;
   logic tx_rdy, rx_rdy, acc_rdy, nack_flag, seq_busy, link_busy;
   logic bus_vld, bus_rd;
   logic [1:0] bus_op;
   logic [ADDR_W-1:0] bus_addr;
   logic [7:0] bus_wbyte;
   logic bus_rdy = 1'b0;
   logic bus_ack = 1'b1;
   logic [7:0] bus_rbyte = '0;

   always #2 clk = ~clk;

   cnt_xfer_seq dut (.*);

   int errors = 0;
   int checks = 0;
   int n_start = 0, n_wr = 0, n_rd = 0, n_stop = 0;
   int nack_at = -1;
   bit nack_addr = 1'b0;
   logic [ADDR_W-1:0] last_addr;
   logic last_rd;
   logic [7:0] wr_log [0:63];

   // bus target model: random completion delay, scripted acknowledge
   initial begin
      forever begin
         @(negedge clk);
         bus_rdy = ($urandom % 3) != 0;
         #1;
         if (bus_vld && bus_rdy) begin
            case (bus_op)
               2'd0: begin
                  bus_ack = !nack_addr; last_addr = bus_addr; last_rd = bus_rd; n_start++;
               end
               2'd1: begin
                  bus_ack = (n_wr != nack_at);
                  if (n_wr < 64) wr_log[n_wr] = bus_wbyte;
                  n_wr++;
               end
               2'd2: begin
                  bus_ack = 1'b1; bus_rbyte = 8'h30 + 8'(n_rd); n_rd++;
               end
               default: begin bus_ack = 1'b1; n_stop++; end
            endcase
         end
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog R13 act=timeout exp=completion");
      summary();
      $finish;
   end

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      ctl_wdata = v; ctl_wr = 1'b1; @(negedge clk); ctl_wr = 1'b0;
   endtask
   task automatic set_cnt(input int v);
      cnt_wdata = CNT_W'(v); cnt_wr = 1'b1; @(negedge clk); cnt_wr = 1'b0;
   endtask
   task automatic push(input logic [7:0] b);
      host_tx_byte = b; host_tx_vld = 1'b1; @(negedge clk); host_tx_vld = 1'b0;
   endtask
   task automatic pop_chk(input string tag, input logic [7:0] exp);
      chk(tag, rx_head, exp);
      host_rx_pop = 1'b1; @(negedge clk); host_rx_pop = 1'b0;
   endtask
   task automatic wait_idle();
      repeat (2) @(negedge clk);
      while (seq_busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask
   task automatic clr_log();
      n_start = 0; n_wr = 0; n_rd = 0; n_stop = 0; nack_at = -1; nack_addr = 1'b0;
   endtask

   initial begin
      logic [7:0] exp_b [0:3];
      void'($urandom(32'h1D2C));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      chk("R1 reset ctl", ctl_q, 16'h0000);
      chk("R4 reset count", cnt_live, 0);
      chk("R13 reset bus_vld", bus_vld, 0);
      chk("R7 reset acc_rdy", acc_rdy, 0);

      // R1 masking
      wr_ctl(16'h7F7A);
      @(negedge clk);
      chk("R1 masked control", ctl_q, 16'h4F02);

      // R3 refused address
      clr_log(); nack_addr = 1'b1; tgt_addr = 10'h02A;
      set_cnt(3);
      wr_ctl(16'h8603);
      wait_idle();
      chk("R2 start count", n_start, 1);
      chk("R2 start addr", last_addr, 10'h02A);
      chk("R2 start dir write", last_rd, 0);
      chk("R3 nack set", nack_flag, 1);
      chk("R3 no data op", n_wr, 0);
      chk("R3 control stop+start cleared", ctl_q, 16'h8600);
      chk("R3 link not claimed", link_busy, 0);

      // R10 disable resets
      push(8'h01); push(8'h02);
      chk("R10 pre level", tx_level, 2);
      wr_ctl(16'h0000);
      @(negedge clk);
      chk("R10 tx emptied", tx_level, 0);
      chk("R10 nack cleared", nack_flag, 0);
      chk("R10 control value", ctl_q, 16'h0000);

      // R4/R6 count transmit with stop
      clr_log(); tgt_addr = 10'h055;
      set_cnt(3);
      push(8'hAA); push(8'hBB); push(8'hCC);
      wr_ctl(16'h8603);
      wait_idle();
      chk("R4 write count", n_wr, 3);
      chk("R4 byte0", wr_log[0], 8'hAA);
      chk("R4 byte1", wr_log[1], 8'hBB);
      chk("R4 byte2", wr_log[2], 8'hCC);
      chk("R6 stop issued", n_stop, 1);
      chk("R6 control after stop", ctl_q, 16'h8600);
      chk("R6 count reloaded", cnt_live, 3);
      chk("R6 link released", link_busy, 0);

      // R7 exhaustion without stop, R12 clear, later stop
      clr_log();
      set_cnt(2);
      push(8'h11); push(8'h22); push(8'h33);
      wr_ctl(16'h8601);
      wait_idle();
      chk("R7 write count", n_wr, 2);
      chk("R7 second byte", wr_log[1], 8'h22);
      chk("R7 acc_rdy set", acc_rdy, 1);
      chk("R7 master cleared", ctl_q, 16'h8200);
      chk("R7 no stop", n_stop, 0);
      chk("R7 link held", link_busy, 1);
      chk("R7 count at zero", cnt_live, 0);
      evt_clr = 2'b01; @(negedge clk); evt_clr = 2'b00;
      chk("R12 acc cleared", acc_rdy, 0);
      wr_ctl(16'h8602);
      wait_idle();
      chk("R7 late stop issued", n_stop, 1);
      chk("R6 leftover tx emptied", tx_level, 0);
      chk("R6 count reloaded 2", cnt_live, 2);

      // R5 count receive, count beyond buffer depth
      clr_log();
      set_cnt(6);
      wr_ctl(16'h8403);
      repeat (40) @(negedge clk);
      chk("R2 start dir read", last_rd, 1);
      chk("R5 reads stop at full", n_rd, 4);
      chk("R5 rx level full", rx_level, 4);
      chk("R5 rx_rdy", rx_rdy, 1);
      chk("R5 count remaining", cnt_live, 2);
      for (int i = 0; i < 4; i++) pop_chk("R5 rx order", 8'h30 + 8'(i));
      wait_idle();
      chk("R5 total reads", n_rd, 6);
      chk("R6 stop after rx", n_stop, 1);
      pop_chk("R5 rx byte4", 8'h34);
      pop_chk("R5 rx byte5", 8'h35);
      chk("R5 rx_rdy empty", rx_rdy, 0);

      // R8 repeat receive
      clr_log();
      set_cnt(1);
      wr_ctl(16'h8405);
      repeat (40) @(negedge clk);
      chk("R8 rx fills past count", n_rd, 4);
      chk("R8 rx_rdy when full", rx_rdy, 1);
      chk("R8 count untouched", cnt_live, 1);
      wr_ctl(16'h8002);
      wait_idle();
      chk("R8 stop issued", n_stop, 1);
      chk("R8 no extra reads", n_rd, 4);
      chk("R8 stop bit cleared", ctl_q[1], 0);
      for (int i = 0; i < 4; i++) pop_chk("R8 rx order", 8'h30 + 8'(i));

      // R8 repeat transmit
      clr_log();
      set_cnt(0);
      push(8'hD0); push(8'hD1); push(8'hD2); push(8'hD3);
      wr_ctl(16'h8605);
      while (n_wr < 4) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R8 tx drained", tx_level, 0);
      chk("R8 tx_rdy held", tx_rdy, 1);
      push(8'h5A);
      repeat (10) @(negedge clk);
      chk("R8 extra byte sent", n_wr, 5);
      chk("R8 extra byte value", wr_log[4], 8'h5A);
      wr_ctl(16'h8002);
      wait_idle();
      chk("R8 tx stop", n_stop, 1);

      // R9 refused data byte
      clr_log(); nack_at = 1;
      set_cnt(4);
      push(8'hE0); push(8'hE1); push(8'hE2); push(8'hE3);
      wr_ctl(16'h8603);
      wait_idle();
      chk("R9 writes until refusal", n_wr, 2);
      chk("R9 nack set", nack_flag, 1);
      chk("R9 stop cleared", ctl_q[1], 0);
      chk("R9 no stop op", n_stop, 0);
      chk("R9 count after one ack", cnt_live, 3);
      chk("R9 refused byte kept", tx_level, 3);
      evt_clr = 2'b10; @(negedge clk); evt_clr = 2'b00;
      chk("R12 nack cleared", nack_flag, 0);
      wr_ctl(16'h0000);
      @(negedge clk);
      chk("R10 link dropped", link_busy, 0);
      chk("R10 count cleared", cnt_live, 0);

      // R11 push into full buffer
      clr_log();
      set_cnt(4);
      push(8'hC0); push(8'hC1); push(8'hC2); push(8'hC3); push(8'hEE);
      chk("R11 level saturates", tx_level, 4);
      wr_ctl(16'h8603);
      wait_idle();
      chk("R11 four writes", n_wr, 4);
      chk("R11 last byte not dropped one", wr_log[3], 8'hC3);

      // random transfers
      for (int it = 0; it < 24; it++) begin
         int len;
         len = 1 + int'($urandom % 4);
         clr_log();
         tgt_addr = ADDR_W'($urandom % 128);
         set_cnt(len);
         if (it % 2 == 0) begin
            for (int k = 0; k < len; k++) begin
               exp_b[k] = 8'($urandom);
               push(exp_b[k]);
            end
            wr_ctl(16'h8603);
            wait_idle();
            chk("R4 random write count", n_wr, len);
            for (int k = 0; k < len; k++) chk("R4 random byte", wr_log[k], exp_b[k]);
            chk("R6 random reload", cnt_live, len);
         end else begin
            wr_ctl(16'h8403);
            wait_idle();
            chk("R5 random read count", n_rd, len);
            for (int k = 0; k < len; k++) pop_chk("R5 random rx", 8'h30 + 8'(k));
         end
         chk("R2 random addr", last_addr, tgt_addr);
      end

      summary();
      $finish;
   end
endmodule